// File: doc/BRIEF.md
# Guarded Clock Control Register Unit

This block holds the clock configuration of a small microcontroller in three byte-wide registers that a bus can write and read. Each write is checked against hardware interlocks before it is committed. The interlocks reject any write that would stop the oscillator the CPU is running from. They reject a switch to a source that is stopped. They enforce one change per reset on two configuration bits, and they allow oscillator pin configuration only while the main oscillator is stopped and the subsystem clock is not in use. A rejected write leaves every register as it was and raises a one-cycle error pulse.

When the high-frequency amplifier bit is set while the CPU runs from an external clock on the main path, the block drops its CPU clock enable for a fixed number of source clock cycles. Source cycles arrive as single-cycle strobes on `src_tick`, so the hold can be counted in the block's own clock domain.

Register map (address on `addr`): 0 = mode register (bit 0 high-frequency amplifier, bit 4 external clock enable, bit 6 oscillator pin select, bits 3 and 7 reserved, all other bits read 0). 1 = oscillator stop register (bit 0 internal oscillator stop, bit 7 main oscillator stop). 2 = select register (bit 0 main/internal select, 1 = main; bit 1 subsystem select). 3 is unmapped.

Top module: `clkctl_guard`

## Requirements
- R1: After reset the mode register reads 0x00, the stop register reads 0x80 (main stopped, internal running), the select register reads 0x00, address 3 reads 0x00, `cpu_clk_en` is 1 and `wr_err` is 0.
- R2: The high-frequency bit (mode bit 0) may change once per reset. A later write that would change it is rejected.
- R3: The oscillator pin select bit (mode bit 6) may change once per reset. A later write that would change it is rejected.
- R4: A write changing mode bit 4 or bit 6 is rejected unless the main oscillator stop bit is 1 and the subsystem select is 0.
- R5: A write setting the main stop bit (stop bit 7) is rejected unless the main/internal select is 0 or the subsystem select is 1.
- R6: A write clearing the main stop bit is rejected while mode bit 6 is 0.
- R7: A write setting the internal stop bit (stop bit 0) is rejected unless the main/internal select is 1 or the subsystem select is 1.
- R8: Mode bits 3 and 7 always read 0. Writing 1 to them is discarded without an error.
- R9: A rejected write leaves all registers unchanged and drives `wr_err` high for exactly the one cycle after the write edge. An accepted write leaves `wr_err` low. Any write to address 3 is rejected.
- R10: When the high-frequency bit goes from 0 to 1 while the CPU runs from the external clock (select bit 0 = 1, subsystem select 0, mode bits 4 and 6 both 1), `cpu_clk_en` goes low from the next edge for exactly 160 `src_tick` strobes. Setting the bit in any other state causes no hold.
- R11: Setting select bit 0 is rejected while the main oscillator is stopped. Clearing it is rejected while the internal oscillator is stopped. Setting the subsystem select is rejected while `sub_ready` is 0. Clearing it is rejected while the source named by select bit 0 is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| wr_err | output | 1 | One-cycle pulse after a rejected write |
| sub_ready | input | 1 | Subsystem oscillator is running |
| src_tick | input | 1 | One strobe per source clock cycle |
| cpu_clk_en | output | 1 | CPU clock enable, low during the hold |

## Verification
On every cycle, the embedded properties check the following. Locked bits never move. A stop bit rises or falls only when the select state of the previous cycle allowed it. The pin configuration bits change only with the main oscillator stopped. An error pulse follows only a write. A fall of the clock enable coincides with a rise of the high-frequency bit. Only the bench scenarios can show the following: a forbidden write leaves the readable value intact, the reserved bits are discarded across all write values, and the hold lasts exactly 160 source strobes whether the strobes come every cycle or every other cycle. The bench also shows that no hold occurs when the CPU is off the external clock.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    localparam int DW = 8;
    typedef logic [1:0]    reg_addr_t;
    typedef logic [DW-1:0] byte_t;

    localparam reg_addr_t A_MODE = 2'd0;
    localparam reg_addr_t A_STOP = 2'd1;
    localparam reg_addr_t A_SEL  = 2'd2;
    localparam reg_addr_t A_NONE = 2'd3;

    localparam int MB_HF   = 0;
    localparam int MB_EXT  = 4;
    localparam int MB_PIN  = 6;
    localparam int SB_INT  = 0;
    localparam int SB_MAIN = 7;
    localparam int LB_MAIN = 0;
    localparam int LB_SUB  = 1;

    typedef struct packed {
        logic hf;
        logic ext_en;
        logic pin_sel;
        logic main_stop;
        logic int_stop;
        logic main_sel;
        logic sub_sel;
    } ctl_t;

    typedef struct packed {
        logic hf;
        logic pin;
    } lock_t;

    localparam ctl_t CTL_RESET = '{hf: 1'b0, ext_en: 1'b0, pin_sel: 1'b0,
                                   main_stop: 1'b1, int_stop: 1'b0,
                                   main_sel: 1'b0, sub_sel: 1'b0};

    function automatic byte_t view_reg(ctl_t c, reg_addr_t a);
        byte_t r;
        r = '0;
        case (a)
            A_MODE: begin
                r[MB_HF]  = c.hf;
                r[MB_EXT] = c.ext_en;
                r[MB_PIN] = c.pin_sel;
            end
            A_STOP: begin
                r[SB_INT]  = c.int_stop;
                r[SB_MAIN] = c.main_stop;
            end
            A_SEL: begin
                r[LB_MAIN] = c.main_sel;
                r[LB_SUB]  = c.sub_sel;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic ctl_t merge_reg(ctl_t c, reg_addr_t a, byte_t d);
        ctl_t n;
        n = c;
        case (a)
            A_MODE: begin
                n.hf      = d[MB_HF];
                n.ext_en  = d[MB_EXT];
                n.pin_sel = d[MB_PIN];
            end
            A_STOP: begin
                n.int_stop  = d[SB_INT];
                n.main_stop = d[SB_MAIN];
            end
            A_SEL: begin
                n.main_sel = d[LB_MAIN];
                n.sub_sel  = d[LB_SUB];
            end
            default: n = c;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/clkctl_rules.sv
module clkctl_rules
    import clkctl_pkg::*;
(
    input  ctl_t      cur,
    input  lock_t     lock,
    input  logic      sub_ready,
    input  logic      wr_en,
    input  reg_addr_t addr,
    input  byte_t     wdata,
    output ctl_t      nxt,
    output logic      accept,
    output logic      reject
);
    logic chg_pin, chg_ext, chg_hf;
    logic v_lock, v_pins, v_stop, v_sel, viol;

    always_comb begin
        nxt     = merge_reg(cur, addr, wdata);
        chg_hf  = nxt.hf != cur.hf;
        chg_pin = nxt.pin_sel != cur.pin_sel;
        chg_ext = nxt.ext_en != cur.ext_en;

        v_lock = (chg_hf & lock.hf) | (chg_pin & lock.pin);
        v_pins = (chg_pin | chg_ext) & (!cur.main_stop | cur.sub_sel);
        v_stop = (nxt.main_stop & !cur.main_stop & cur.main_sel & !cur.sub_sel)
               | (!nxt.main_stop & cur.main_stop & !cur.pin_sel)
               | (nxt.int_stop & !cur.int_stop & !cur.main_sel & !cur.sub_sel);
        v_sel  = (nxt.main_sel & !cur.main_sel & cur.main_stop)
               | (!nxt.main_sel & cur.main_sel & cur.int_stop)
               | (nxt.sub_sel & !cur.sub_sel & !sub_ready)
               | (!nxt.sub_sel & cur.sub_sel &
                  (cur.main_sel ? cur.main_stop : cur.int_stop));

        viol   = (addr == A_NONE) | v_lock | v_pins | v_stop | v_sel;
        accept = wr_en & !viol;
        reject = wr_en & viol;
    end
endmodule

// File: rtl/clkctl_stall.sv
module clkctl_stall #(
    parameter int STALL_CYCLES = 160
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic hold
);
    localparam int CW = $clog2(STALL_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(STALL_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= LOAD;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign hold = cnt != '0;

    a_r10_hold_starts_full: assert property (@(posedge clk) disable iff (rst)
        $past(start) |-> cnt == LOAD);
endmodule

// File: rtl/clkctl_guard.sv
module clkctl_guard
    import clkctl_pkg::*;
#(
    parameter int STALL_CYCLES = 160
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    output logic         wr_err,
    input  logic         sub_ready,
    input  logic         src_tick,
    output logic         cpu_clk_en
);
    ctl_t  ctl_q, ctl_nxt;
    lock_t lock_q;
    logic  accept, reject, err_q, on_ext, stall_go, hold;

    clkctl_rules u_rules (
        .cur(ctl_q), .lock(lock_q), .sub_ready(sub_ready), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .nxt(ctl_nxt), .accept(accept), .reject(reject)
    );

    assign on_ext   = ctl_q.main_sel & !ctl_q.sub_sel & ctl_q.pin_sel & ctl_q.ext_en;
    assign stall_go = accept & ctl_nxt.hf & !ctl_q.hf & on_ext;

    clkctl_stall #(.STALL_CYCLES(STALL_CYCLES)) u_stall (
        .clk(clk), .rst(rst), .start(stall_go), .tick(src_tick), .hold(hold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= CTL_RESET;
            lock_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= reject;
            if (accept) begin
                ctl_q      <= ctl_nxt;
                lock_q.hf  <= lock_q.hf  | (ctl_nxt.hf != ctl_q.hf);
                lock_q.pin <= lock_q.pin | (ctl_nxt.pin_sel != ctl_q.pin_sel);
            end
        end
    end

    assign rdata      = view_reg(ctl_q, addr);
    assign wr_err     = err_q;
    assign cpu_clk_en = !hold;

    a_r2_hf_locked: assert property (@(posedge clk) disable iff (rst)
        lock_q.hf |=> ctl_q.hf == $past(ctl_q.hf));
    a_r3_pin_locked: assert property (@(posedge clk) disable iff (rst)
        lock_q.pin |=> ctl_q.pin_sel == $past(ctl_q.pin_sel));
    a_r4_pins_need_stop: assert property (@(posedge clk) disable iff (rst)
        (!$stable(ctl_q.ext_en) || !$stable(ctl_q.pin_sel)) |->
            ($past(ctl_q.main_stop) && !$past(ctl_q.sub_sel)));
    a_r5_main_stop_safe: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.main_stop) |-> (!$past(ctl_q.main_sel) || $past(ctl_q.sub_sel)));
    a_r6_main_start_pins: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_q.main_stop) |-> $past(ctl_q.pin_sel));
    a_r7_int_stop_safe: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.int_stop) |-> ($past(ctl_q.main_sel) || $past(ctl_q.sub_sel)));
    a_r9_err_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(wr_en));
    a_r10_hold_on_hf: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_clk_en) |-> $rose(ctl_q.hf));
endmodule

// File: tb/clkctl_guard_test.sv
module clkctl_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       wr_err;
    logic       sub_ready = 1'b0;
    logic       src_tick = 1'b1;
    logic       cpu_clk_en;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    clkctl_guard uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wr_err(wr_err), .sub_ready(sub_ready),
        .src_tick(src_tick), .cpu_clk_en(cpu_clk_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: act=%0d cycles exp=<%0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string req, input bit exp_err);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        chk(req, int'(wr_err), int'(exp_err));
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [7:0] exp);
        addr = a; #1;
        chk(req, int'(rdata), int'(exp));
    endtask

    task automatic to_external();
        do_reset();
        wr(2'd0, 8'h50, "R4 pins set", 0);
        wr(2'd1, 8'h00, "R6 main start", 0);
        wr(2'd2, 8'h01, "R11 select main", 0);
    endtask

    task automatic measure(input bit alternate, output int low, output int ticks);
        low = 0; ticks = 0;
        while (!cpu_clk_en && low < 2000) begin
            low++;
            ticks += int'(src_tick);
            @(posedge clk); #1;
            if (alternate) src_tick = ~src_tick;
        end
    endtask

    initial begin
        int low, ticks;
        do_reset();
        // R1 reset state
        rd(2'd0, "R1 mode reset", 8'h00);
        rd(2'd1, "R1 stop reset", 8'h80);
        rd(2'd2, "R1 sel reset", 8'h00);
        rd(2'd3, "R1 unmapped", 8'h00);
        chk("R1 clk en", int'(cpu_clk_en), 1);
        chk("R1 err", int'(wr_err), 0);

        // R8 / R4: sweep every mode write from the reset state
        for (int v = 0; v < 256; v++) begin
            do_reset();
            wr(2'd0, 8'(v), "R8 sweep err", 0);
            rd(2'd0, "R8 sweep read", 8'(v) & 8'h51);
        end

        do_reset();
        wr(2'd3, 8'hFF, "R9 unmapped write", 1);
        @(posedge clk); #1;
        chk("R9 single pulse", int'(wr_err), 0);
        wr(2'd1, 8'h81, "R7 int stop on internal", 1);
        rd(2'd1, "R7 kept", 8'h80);
        wr(2'd1, 8'h00, "R6 main start pins port", 1);
        rd(2'd1, "R6 kept", 8'h80);
        wr(2'd2, 8'h01, "R11 main sel while stopped", 1);
        rd(2'd2, "R11 kept", 8'h00);
        wr(2'd2, 8'h02, "R11 sub without ready", 1);
        rd(2'd2, "R11 sub kept", 8'h00);
        sub_ready = 1'b1;
        wr(2'd2, 8'h02, "R11 sub ready", 0);
        rd(2'd2, "R11 sub set", 8'h02);
        wr(2'd0, 8'h50, "R4 pins with sub", 1);
        rd(2'd0, "R4 kept", 8'h00);
        wr(2'd2, 8'h00, "R11 sub back", 0);
        wr(2'd0, 8'hD8, "R8 reserved discard", 0);
        rd(2'd0, "R8 read", 8'h50);
        wr(2'd0, 8'h10, "R3 pin relock", 1);
        rd(2'd0, "R3 kept", 8'h50);
        wr(2'd1, 8'h00, "R6 main start", 0);
        rd(2'd1, "R6 started", 8'h00);
        wr(2'd0, 8'h40, "R4 ext while running", 1);
        rd(2'd0, "R4 ext kept", 8'h50);
        wr(2'd2, 8'h01, "R11 select main", 0);
        wr(2'd1, 8'h80, "R5 stop active main", 1);
        rd(2'd1, "R5 kept", 8'h00);
        wr(2'd1, 8'h01, "R7 int stop on main", 0);
        rd(2'd1, "R7 stopped", 8'h01);
        wr(2'd2, 8'h00, "R11 back to stopped int", 1);
        rd(2'd2, "R11 kept main", 8'h01);

        // R10 hold with a strobe every cycle
        src_tick = 1'b1;
        wr(2'd0, 8'h51, "R10 hf set", 0);
        measure(0, low, ticks);
        chk("R10 hold cycles", low, 160);
        chk("R10 hold ticks", ticks, 160);
        rd(2'd0, "R10 hf read", 8'h51);
        wr(2'd0, 8'h50, "R2 hf relock", 1);
        rd(2'd0, "R2 kept", 8'h51);
        chk("R2 no new hold", int'(cpu_clk_en), 1);

        wr(2'd1, 8'h00, "R7 int restart", 0);
        wr(2'd2, 8'h00, "R11 back to int", 0);
        wr(2'd1, 8'h80, "R5 stop idle main", 0);
        rd(2'd1, "R5 stopped", 8'h80);

        // R10 hold with a strobe every other cycle
        to_external();
        src_tick = 1'b0;
        wr(2'd0, 8'h51, "R10 hf set alt", 0);
        measure(1, low, ticks);
        chk("R10 alt ticks", ticks, 160);
        chk("R10 alt cycles", (low >= 319 && low <= 320) ? 1 : 0, 1);
        src_tick = 1'b1;

        // R10 no hold off the external clock
        do_reset();
        wr(2'd0, 8'h01, "R10 hf on internal", 0);
        for (int i = 0; i < 5; i++) begin
            chk("R10 no hold", int'(cpu_clk_en), 1);
            @(posedge clk); #1;
        end
        wr(2'd0, 8'h00, "R2 hf clear locked", 1);
        rd(2'd0, "R2 still set", 8'h01);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule